// File: doc/BRIEF.md
# Multi-Queue Write Port Controller

This block is the write side of an eight-queue FIFO device. Up to eight such devices can share one address bus. A 6-bit address carries two fields. The low three bits pick a queue inside a device. The high three bits pick one of the cascaded devices. An address-enable strobe loads a new target. The change reaches the write path through a two-stage pipeline, so words written just after a reselection still land in the old queue.

While the write enable (active low) is asserted and the active device field equals the static device ID, the block accepts one data word per clock. Each accepted word goes to a shared memory that is split into equal partitions, one per queue. The memory address is the queue number followed by that queue's write pointer. A write to a full queue is dropped and raises an overflow pulse.

A second strobe reuses the high address bits to pick which device drives the shared almost-full flag bus. Only the picked device drives its almost-full vector onto that bus.

Top module: `mq_write_port`

## Requirements
- R1: After synchronous reset, every queue count and pointer is zero and the pending and active selections are queue 0 of device 0. The flag-bus device select is 0, no memory write or overflow is reported, and `q_full` is all zero.
- R2: On a rising edge with `waddr_en` high, the whole 6-bit `waddr` is captured as the pending selection. This happens whatever the level of `wr_n`.
- R3: On an accepted write, `mem_addr` is {queue[2:0], pointer[3:0]} (queue in bits [6:4]) and `mem_wdata` is the input word. The pointer of that queue then advances by one. Both outputs are registered and appear after that edge.
- R4: Writes on the select edge and on the next edge still go to the previously active queue. From the second edge after the select edge, writes go to the newly selected queue.
- R5: A write is accepted only when the active device field (`waddr` bits [5:3]) equals `dev_id`. Otherwise `wr_n` low has no effect on memory, pointers, full status or overflow.
- R6: Once a queue holds DEPTH words its `q_full` bit is set. A further write to it is dropped: `mem_we` stays low and `overflow` pulses high for exactly that write.
- R7: On a rising edge with `flag_strobe` high, `waddr` bits [5:3] become the flag-bus device select and bits [2:0] are ignored. A write on that same edge still goes to the current queue.
- R8: When the flag-bus device select equals `dev_id`, `afull_oe` is 1. In that case `afull_bus` bit i is 1 exactly when queue i holds at least DEPTH-AF_GAP words. Otherwise `afull_oe` is 0 and `afull_bus` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_id | input | 3 | Static ID of this device in the cascade |
| waddr | input | 6 | Device field [5:3] and queue field [2:0] |
| waddr_en | input | 1 | Loads `waddr` as the pending write selection |
| flag_strobe | input | 1 | Loads `waddr[5:3]` as the flag-bus device select |
| wr_n | input | 1 | Write enable, active low |
| wdata | input | 36 | Write data word |
| mem_we | output | 1 | Registered write strobe to the shared memory |
| mem_addr | output | 7 | Registered memory address {queue, pointer} |
| mem_wdata | output | 36 | Registered memory write data |
| overflow | output | 1 | One-cycle pulse when a write to a full queue is dropped |
| q_full | output | 8 | Full status, one bit per queue |
| afull_bus | output | 8 | Almost-full vector, nonzero only while this device drives the bus |
| afull_oe | output | 1 | High while this device owns the flag bus |

## Verification
The hardest case to reach is the switchover window. A reselection must arrive while writes are streaming. The bench must then show that exactly two more words reach the old queue before the new queue takes over. A second hard case is the overflow pulse, which needs one queue driven completely full through the ports. The stimulus keeps `wr_n` low across the select edge and the next two edges. It then keeps writing into the new queue past DEPTH words. A reference model in the bench carries its own copy of the two-stage selection and the per-queue counts, and it predicts every memory address, overflow pulse and flag vector.

// File: rtl/mq_wp_pkg.sv
package mq_wp_pkg;
   localparam int unsigned QSEL_W = 3;
   localparam int unsigned DSEL_W = 3;
   localparam int unsigned WORD_W = 36;

   typedef struct packed {
      logic [DSEL_W-1:0] dev;
      logic [QSEL_W-1:0] q;
   } wsel_t;
endpackage

// File: rtl/mq_sel_pipe.sv
module mq_sel_pipe #(
   parameter int unsigned QB = 3,
   parameter int unsigned DB = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [QB+DB-1:0] addr,
   input  logic          addr_en,
   input  logic          flag_stb,
   output logic [QB-1:0] act_q,
   output logic [DB-1:0] act_dev,
   output logic [DB-1:0] flag_dev
);
   localparam int unsigned AW = QB + DB;

   logic [AW-1:0] pend_r;
   logic [AW-1:0] act_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_r   <= '0;
         act_r    <= '0;
         flag_dev <= '0;
      end else begin
         act_r <= pend_r;
         if (addr_en)  pend_r   <= addr;
         if (flag_stb) flag_dev <= addr[AW-1:QB];
      end
   end

   assign act_q   = act_r[QB-1:0];
   assign act_dev = act_r[AW-1:QB];
endmodule

// File: rtl/mq_qcount.sv
module mq_qcount #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned AF_GAP = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         inc,
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         full,
   output logic                         afull
);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_AT  = CW'(DEPTH);
   localparam logic [CW-1:0] AFULL_AT = CW'(DEPTH - AF_GAP);

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign full  = (cnt == FULL_AT);
   assign afull = (cnt >= AFULL_AT);
endmodule

// File: rtl/mq_write_port.sv
module mq_write_port
   import mq_wp_pkg::*;
#(
   parameter int unsigned QB     = QSEL_W,
   parameter int unsigned DB     = DSEL_W,
   parameter int unsigned DW     = WORD_W,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned AF_GAP = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [DB-1:0]                 dev_id,
   input  logic [QB+DB-1:0]              waddr,
   input  logic                          waddr_en,
   input  logic                          flag_strobe,
   input  logic                          wr_n,
   input  logic [DW-1:0]                 wdata,
   output logic                          mem_we,
   output logic [QB+$clog2(DEPTH)-1:0]   mem_addr,
   output logic [DW-1:0]                 mem_wdata,
   output logic                          overflow,
   output logic [(1<<QB)-1:0]            q_full,
   output logic [(1<<QB)-1:0]            afull_bus,
   output logic                          afull_oe
);
   localparam int unsigned NQ = 1 << QB;
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("mq_write_port: DEPTH must be a power of two, at least 2");
      end
      if (AF_GAP >= DEPTH) begin : g_bad_gap
         $error("mq_write_port: AF_GAP must be below DEPTH");
      end
      if (QB < 1 || DB < 1) begin : g_bad_sel
         $error("mq_write_port: selection fields need at least one bit");
      end
   endgenerate

   logic [QB-1:0] act_q;
   logic [DB-1:0] act_dev;
   logic [DB-1:0] flag_dev;

   mq_sel_pipe #(.QB(QB), .DB(DB)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .addr     (waddr),
      .addr_en  (waddr_en),
      .flag_stb (flag_strobe),
      .act_q    (act_q),
      .act_dev  (act_dev),
      .flag_dev (flag_dev)
   );

   logic [NQ-1:0]  inc_vec;
   logic [NQ-1:0]  full_vec;
   logic [NQ-1:0]  afull_vec;
   logic [CW-1:0]  cnt_arr [NQ];

   logic dev_hit;
   logic wr_try;
   logic sel_full;
   logic wr_ok;

   assign dev_hit  = (act_dev == dev_id);
   assign wr_try   = !wr_n && dev_hit;
   assign sel_full = full_vec[act_q];
   assign wr_ok    = wr_try && !sel_full;

   for (genvar gi = 0; gi < NQ; gi++) begin : g_q
      assign inc_vec[gi] = wr_ok && (act_q == QB'(gi));
      mq_qcount #(.DEPTH(DEPTH), .AF_GAP(AF_GAP)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .inc   (inc_vec[gi]),
         .cnt   (cnt_arr[gi]),
         .full  (full_vec[gi]),
         .afull (afull_vec[gi])
      );
   end

   logic [PW-1:0] sel_ptr;
   assign sel_ptr = cnt_arr[act_q][PW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         overflow  <= 1'b0;
      end else begin
         mem_we   <= wr_ok;
         overflow <= wr_try && sel_full;
         if (wr_ok) begin
            mem_addr  <= {act_q, sel_ptr};
            mem_wdata <= wdata;
         end
      end
   end

   assign q_full    = full_vec;
   assign afull_oe  = (flag_dev == dev_id);
   assign afull_bus = afull_oe ? afull_vec : '0;
endmodule

// File: rtl/mq_write_port_chk.sv
module mq_write_port_chk #(
   parameter int unsigned QB = 3,
   parameter int unsigned DB = 3,
   parameter int unsigned AW = 7
) (
   input logic          clk,
   input logic          rst,
   input logic [DB-1:0] dev_id,
   input logic [QB+DB-1:0] waddr,
   input logic          waddr_en,
   input logic          flag_strobe,
   input logic          wr_n,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          overflow,
   input logic [(1<<QB)-1:0] q_full,
   input logic [(1<<QB)-1:0] afull_bus,
   input logic          afull_oe,
   input logic [QB-1:0] act_q,
   input logic [DB-1:0] act_dev
);
   assert_we_ovf_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(mem_we && overflow));

   assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (($past(q_full) & ~q_full) == '0));

   assert_dev_match_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_we || overflow) |-> $past(act_dev == dev_id && !wr_n));

   assert_old_queue_R4: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_addr[AW-1:AW-QB] == $past(act_q)));

   assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
      waddr_en |=> ##1 (act_q == $past(waddr[QB-1:0], 2)));

   assert_flag_sel_R7: assert property (@(posedge clk) disable iff (rst)
      flag_strobe |=> (afull_oe == ($past(waddr[QB+DB-1:QB]) == dev_id)));

   assert_afull_cover_R8: assert property (@(posedge clk) disable iff (rst)
      afull_oe |-> ((q_full & ~afull_bus) == '0));

   assert_afull_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !afull_oe |-> (afull_bus == '0));
endmodule

bind mq_write_port mq_write_port_chk #(
   .QB(QB), .DB(DB), .AW(QB + $clog2(DEPTH))
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .dev_id      (dev_id),
   .waddr       (waddr),
   .waddr_en    (waddr_en),
   .flag_strobe (flag_strobe),
   .wr_n        (wr_n),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .overflow    (overflow),
   .q_full      (q_full),
   .afull_bus   (afull_bus),
   .afull_oe    (afull_oe),
   .act_q       (act_q),
   .act_dev     (act_dev)
);

// File: tb/test_mq_write_port.sv
module test_mq_write_port;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AF_GAP = 2;
   localparam logic [2:0] DEV = 3'd5;

   logic        clk = 1'b0;
   logic        rst;
   logic [5:0]  waddr;
   logic        waddr_en, flag_strobe, wr_n;
   logic [35:0] wdata;
   logic        mem_we, overflow, afull_oe;
   logic [6:0]  mem_addr;
   logic [35:0] mem_wdata;
   logic [7:0]  q_full, afull_bus;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mq_write_port #(.DEPTH(DEPTH), .AF_GAP(AF_GAP)) i_mq_write_port (
      .clk(clk), .rst(rst), .dev_id(DEV), .waddr(waddr), .waddr_en(waddr_en),
      .flag_strobe(flag_strobe), .wr_n(wr_n), .wdata(wdata),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .overflow(overflow), .q_full(q_full), .afull_bus(afull_bus),
      .afull_oe(afull_oe)
   );

   typedef struct {
      logic        we;
      logic [6:0]  addr;
      logic [35:0] data;
      logic        ovf;
      logic [7:0]  full;
      logic [7:0]  afb;
      logic        oe;
      string       tag;
   } exp_t;

   exp_t sb[$];

   logic [5:0] m_pend, m_act;
   logic [2:0] m_fdev;
   int         m_cnt [8];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pend = '0; m_act = '0; m_fdev = '0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
   endtask

   // driver: applies one cycle of stimulus and pushes the predicted outcome
   task automatic step(input logic wn, input logic en, input logic fs,
                       input logic [5:0] a, input logic [35:0] d,
                       input string tag);
      exp_t e;
      logic [2:0] q;
      logic hit;
      logic [5:0] old_pend;
      @(negedge clk);
      wr_n = wn; waddr_en = en; flag_strobe = fs; waddr = a; wdata = d;
      q   = m_act[2:0];
      hit = !wn && (m_act[5:3] == DEV);
      e.we   = hit && (m_cnt[q] < DEPTH);
      e.ovf  = hit && (m_cnt[q] == DEPTH);
      e.addr = {q, 4'(m_cnt[q])};
      e.data = d;
      e.tag  = tag;
      if (e.we) m_cnt[q]++;
      old_pend = m_pend;
      if (en) m_pend = a;
      m_act = old_pend;
      if (fs) m_fdev = a[5:3];
      e.oe = (m_fdev == DEV);
      for (int i = 0; i < 8; i++) begin
         e.full[i] = (m_cnt[i] == DEPTH);
         e.afb[i]  = e.oe && (m_cnt[i] >= DEPTH - AF_GAP);
      end
      sb.push_back(e);
   endtask

   // monitor: compares registered outputs just after each edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(mem_we == e.we, e.tag, "mem_we", 64'(mem_we), 64'(e.we));
         if (e.we) begin
            chk(mem_addr == e.addr, e.tag, "mem_addr", 64'(mem_addr), 64'(e.addr));
            chk(mem_wdata == e.data, e.tag, "mem_wdata", 64'(mem_wdata), 64'(e.data));
         end
         chk(overflow == e.ovf, e.tag, "overflow", 64'(overflow), 64'(e.ovf));
         chk(q_full == e.full, e.tag, "q_full", 64'(q_full), 64'(e.full));
         chk(afull_oe == e.oe, e.tag, "afull_oe", 64'(afull_oe), 64'(e.oe));
         chk(afull_bus == e.afb, e.tag, "afull_bus", 64'(afull_bus), 64'(e.afb));
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; wr_n = 1'b1; waddr_en = 1'b0; flag_strobe = 1'b0;
      waddr = '0; wdata = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state, flag select 0 differs from DEV so the bus is quiet
      chk(q_full == 8'h00, "R1", "q_full", 64'(q_full), 64'h0);
      chk(mem_we == 1'b0, "R1", "mem_we", 64'(mem_we), 64'h0);
      chk(overflow == 1'b0, "R1", "overflow", 64'(overflow), 64'h0);
      chk(afull_oe == 1'b0, "R1", "afull_oe", 64'(afull_oe), 64'h0);
      chk(afull_bus == 8'h00, "R1", "afull_bus", 64'(afull_bus), 64'h0);

      // R5: active device after reset is 0, writes are ignored
      step(1'b0, 1'b0, 1'b0, 6'h00, 36'h111, "R5");
      step(1'b0, 1'b0, 1'b0, 6'h00, 36'h112, "R5");

      // R2: select device 5 queue 3 with the write enable idle
      step(1'b1, 1'b1, 1'b0, {DEV, 3'd3}, 36'h0, "R2");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R2");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R2");

      // R3: three words into queue 3
      for (int i = 0; i < 3; i++)
         step(1'b0, 1'b0, 1'b0, 6'h00, 36'hA0000 + 36'(i), "R3");

      // R4: reselect to queue 6 while streaming
      step(1'b0, 1'b1, 1'b0, {DEV, 3'd6}, 36'hB0000, "R4");
      step(1'b0, 1'b0, 1'b0, 6'h00, 36'hB0001, "R4");
      step(1'b0, 1'b0, 1'b0, 6'h00, 36'hB0002, "R4");

      // R6: fill queue 6 and push two words past full
      for (int i = 0; i < 17; i++)
         step(1'b0, 1'b0, 1'b0, 6'h00, 36'hC0000 + 36'(i), "R6");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R6");

      // back to queue 3
      step(1'b1, 1'b1, 1'b0, {DEV, 3'd3}, 36'h0, "R4");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R4");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R4");

      // R7: flag strobe with own device, queue bits 7 ignored, write still lands
      step(1'b0, 1'b0, 1'b1, {DEV, 3'd7}, 36'hD0000, "R7");
      // R8: push queue 3 up to the almost-full mark
      for (int i = 1; i < 9; i++)
         step(1'b0, 1'b0, 1'b0, 6'h00, 36'hD0000 + 36'(i), "R8");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R8");

      // R8: another device takes the flag bus
      step(1'b0, 1'b0, 1'b1, {3'd2, 3'd0}, 36'hE0000, "R8");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R8");

      // R5: select a foreign device, writes after switchover are ignored
      step(1'b0, 1'b1, 1'b0, {3'd4, 3'd3}, 36'hF0000, "R5");
      for (int i = 1; i < 5; i++)
         step(1'b0, 1'b0, 1'b0, 6'h00, 36'hF0000 + 36'(i), "R5");
      step(1'b1, 1'b0, 1'b0, 6'h00, 36'h0, "R5");

      repeat (3) @(posedge clk);
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule